// File: doc/BRIEF.md
# Moving Inversions March Self-Test Engine

This block is a built-in self-test sequencer for a word-addressed synchronous RAM with one read/write port. When started, it covers an inclusive address window. First it writes a data pattern to every word in the window. Then it sweeps upward, checking each word and overwriting it with the complement. Last it sweeps downward, checking for that complement and restoring the original pattern. This sequence is one pass. The engine repeats it for a configured number of passes, and the pass index selects the pattern for each pass.

There are four pattern sources. A solid source alternates all-zeros and all-ones between passes. A walking-byte source steps through twenty byte values and copies the byte into every lane. A pseudo-random source gives each address its own word, and each pass uses a fresh seed. A single-one source rotates the word one bit per address, and the starting bit moves by one position each pass. The engine reproduces the random sequence on read-back by stepping its generator forward on the way up and backward on the way down.

A read returns data one cycle after the address. Each miscompare produces a one-cycle report that carries the address, the expected word and the observed word. The march keeps running after a report.

Top module: `march_bist`

## Requirements
- R1: After a run is accepted, the fill phase writes the pass pattern to every address from lo_addr_i to hi_addr_i in ascending order, one write per cycle. The window requires lo_addr_i <= hi_addr_i.
- R2: The ascending phase handles each address in two cycles, lowest address first. The first cycle issues a read. The next cycle compares the returned word with the pattern and writes its complement to the same address.
- R3: The descending phase starts at the highest address and handles each address the same way. It expects the complement of the pattern and writes the pattern back.
- R4: mode_i = 0 (solid): the pattern is all zeros on even pass indices and all ones on odd pass indices. Passes are numbered from 0.
- R5: mode_i = 2 (random): the generator is a 32-bit register that shifts left. The new bit 0 is the XOR of bits 31, 21, 1 and 0. For pass p, the seed is 32'h1D872B41 XOR (p * 32'h9E3779B9) modulo 2^32, with 1 used in place of a zero result. Address lo gets the seed, and each higher address gets the next state.
- R6: mode_i = 3 (rotate): at offset k from lo in pass p, the pattern is 32'h1 rotated left by (p + k) mod 32.
- R7: mode_i = 1 (walk): let i = p mod 20. The byte is 1<<i for i < 8 and ~(1<<(i-8)) for i in 8..15. For i = 16..19 it is 8'h55, 8'hAA, 8'h33 and 8'hCC. The byte is copied into all four lanes.
- R8: A miscompare raises err_valid_o for one cycle, in the cycle after the compare. err_addr_o, err_exp_o and err_obs_o carry the address, the expected word and the read word. The march continues unchanged.
- R9: start_i is accepted only while idle. busy_o is high for exactly P*5*N cycles, where N is the window size and P is passes_i (a value of 0 counts as 1). done_o then stays high until the next accepted start, which clears it. A start pulse during a run is ignored.
- R10: Mode, window and pass count are sampled when the start is accepted. Changing them during a run does not alter the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (sampled while idle) |
| mode_i | input | 2 | Pattern source select |
| lo_addr_i | input | ADDR_W | Lowest address of the window |
| hi_addr_i | input | ADDR_W | Highest address of the window |
| passes_i | input | PASS_W | Number of passes (0 counts as 1) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_re_o | output | 1 | RAM read enable; data returns next cycle |
| mem_wdata_o | output | 32 | RAM write data |
| mem_rdata_i | input | 32 | RAM read data |
| err_valid_o | output | 1 | Miscompare report strobe |
| err_addr_o | output | ADDR_W | Address of the failing word |
| err_exp_o | output | 32 | Expected word |
| err_obs_o | output | 32 | Word read from RAM |

## Verification
The bench runs a RAM model with an optional stuck-at-one bit mask on one address and rebuilds the full expected write, read and error streams from the requirements. This exposes several classes of defect:
- An engine that reverses the random sequence wrongly on the way down reports false errors in the descending phase.
- A rotate or walk source that mishandles the pass wrap (pass 20 for walk, pass 32 for rotate) writes the wrong word in the fill phase.
- A single-word window at the top address catches an off-by-one in the turn-around and in the end of the window.
- Starting a run again while one is in progress, and changing the configuration mid-run, would lengthen or alter the stream if the inputs were not latched.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int WORD_W   = 32;
  localparam int WALK_SET = 20;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {MODE_SOLID = 2'd0, MODE_WALK = 2'd1, MODE_RAND = 2'd2, MODE_ROT = 2'd3} pat_mode_e;
  typedef enum logic [1:0] {PH_FILL = 2'd0, PH_UP = 2'd1, PH_DOWN = 2'd2} phase_e;

  localparam word_t SEED_SALT = 32'h1D87_2B41;
  localparam word_t SEED_MULT = 32'h9E37_79B9;

  function automatic word_t lfsr_fwd(word_t s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // inverse of lfsr_fwd: recovers the dropped msb from the feedback bit
  function automatic word_t lfsr_back(word_t s);
    return {s[0] ^ s[22] ^ s[2] ^ s[1], s[31:1]};
  endfunction

  function automatic logic [7:0] walk_byte(int idx);
    logic [7:0] b;
    if (idx < 8)       b = 8'(1 << idx);
    else if (idx < 16) b = ~8'(1 << (idx - 8));
    else begin
      case (idx)
        16:      b = 8'h55;
        17:      b = 8'hAA;
        18:      b = 8'h33;
        default: b = 8'hCC;
      endcase
    end
    return b;
  endfunction

  function automatic word_t seed_word(pat_mode_e m, word_t pass);
    word_t s;
    case (m)
      MODE_SOLID: s = pass[0] ? '1 : '0;
      MODE_WALK:  s = {4{walk_byte(int'(pass % WALK_SET))}};
      MODE_RAND: begin
        s = SEED_SALT ^ (pass * SEED_MULT);
        if (s == '0) s = word_t'(1);
      end
      default:    s = word_t'(1) << pass[4:0];
    endcase
    return s;
  endfunction

  function automatic word_t step_word(pat_mode_e m, word_t s, logic down);
    word_t r;
    case (m)
      MODE_RAND: r = down ? lfsr_back(s) : lfsr_fwd(s);
      MODE_ROT:  r = down ? {s[0], s[WORD_W-1:1]} : {s[WORD_W-2:0], s[WORD_W-1]};
      default:   r = s;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/march_patgen.sv
module march_patgen
  import march_pkg::*;
#(
  parameter int PASS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pat_mode_e         mode_i,
  input  logic              load_i,
  input  logic [PASS_W-1:0] pass_i,
  input  logic              adv_i,
  input  logic              down_i,
  output word_t             pat_o
);
  word_t pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pat_q <= '0;
    else if (load_i) pat_q <= seed_word(mode_i, word_t'(pass_i));
    else if (adv_i)  pat_q <= step_word(mode_i, pat_q, down_i);
  end

  assign pat_o = pat_q;

  p_rot_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == MODE_ROT) |=> $onehot(pat_q));
  p_rot_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && mode_i == MODE_ROT) |=> $countones(pat_q) == $countones($past(pat_q)));
  p_rand_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == MODE_RAND) |=> pat_q != '0);
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PASS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  pat_mode_e         mode_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [PASS_W-1:0] passes_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic              ck_o,
  output logic              down_o,
  output pat_mode_e         pg_mode_o,
  output logic              pg_load_o,
  output logic [PASS_W-1:0] pg_pass_o,
  output logic              pg_adv_o,
  output logic              busy_o,
  output logic              done_o
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_CK} state_e;

  state_e            state_q, state_d;
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d, lo_q, hi_q;
  logic [PASS_W-1:0] pass_q, pass_d, last_q;
  pat_mode_e         mode_q;
  logic              done_q, done_d;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    addr_d    = addr_q;
    pass_d    = pass_q;
    done_d    = done_q;
    pg_load_o = 1'b0;
    pg_adv_o  = 1'b0;
    pg_pass_o = pass_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d   = S_WR;
        phase_d   = PH_FILL;
        addr_d    = lo_i;
        pass_d    = '0;
        done_d    = 1'b0;
        pg_load_o = 1'b1;
        pg_pass_o = '0;
      end
      S_WR: begin
        if (addr_q == hi_q) begin
          phase_d   = PH_UP;
          addr_d    = lo_q;
          state_d   = S_RD;
          pg_load_o = 1'b1; // reseed so the check sees the fill sequence
        end else begin
          addr_d   = addr_q + ADDR_W'(1);
          pg_adv_o = 1'b1;
        end
      end
      S_RD: state_d = S_CK;
      S_CK: begin
        state_d = S_RD;
        if (phase_q == PH_UP) begin
          if (addr_q == hi_q) phase_d = PH_DOWN; // pattern already at hi
          else begin
            addr_d   = addr_q + ADDR_W'(1);
            pg_adv_o = 1'b1;
          end
        end else if (addr_q != lo_q) begin
          addr_d   = addr_q - ADDR_W'(1);
          pg_adv_o = 1'b1;
        end else if (pass_q == last_q) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          pass_d    = pass_q + PASS_W'(1);
          pg_pass_o = pass_q + PASS_W'(1);
          pg_load_o = 1'b1;
          phase_d   = PH_FILL;
          addr_d    = lo_q;
          state_d   = S_WR;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= PH_FILL;
      addr_q  <= '0;
      pass_q  <= '0;
      done_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      last_q  <= '0;
      mode_q  <= MODE_SOLID;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      addr_q  <= addr_d;
      pass_q  <= pass_d;
      done_q  <= done_d;
      if (state_q == S_IDLE && start_i) begin
        lo_q   <= lo_i;
        hi_q   <= hi_i;
        mode_q <= mode_i;
        last_q <= (passes_i == '0) ? '0 : passes_i - PASS_W'(1);
      end
    end
  end

  assign pg_mode_o  = (state_q == S_IDLE) ? mode_i : mode_q;
  assign mem_addr_o = addr_q;
  assign mem_we_o   = (state_q == S_WR) || (state_q == S_CK);
  assign mem_re_o   = (state_q == S_RD);
  assign ck_o       = (state_q == S_CK);
  assign down_o     = (phase_q == PH_DOWN);
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;

  p_read_then_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o && mem_addr_o == $past(mem_addr_o));
  p_one_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  p_addr_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && lo_q <= hi_q) |-> (mem_addr_o >= lo_q && mem_addr_o <= hi_q));
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(lo_q) && $stable(hi_q) && $stable(mode_q));
endmodule

// File: rtl/march_check.sv
module march_check
  import march_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ck_i,
  input  logic              down_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             pat_i,
  input  word_t             rdata_i,
  output word_t             wdata_o,
  output logic              err_valid_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output word_t             err_exp_o,
  output word_t             err_obs_o
);
  word_t exp_w;
  logic  miss;

  assign exp_w   = down_i ? ~pat_i : pat_i;
  assign miss    = ck_i && (rdata_i != exp_w);
  assign wdata_o = ck_i ? ~exp_w : pat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_valid_o <= 1'b0;
      err_addr_o  <= '0;
      err_exp_o   <= '0;
      err_obs_o   <= '0;
    end else begin
      err_valid_o <= miss;
      if (miss) begin
        err_addr_o <= addr_i;
        err_exp_o  <= exp_w;
        err_obs_o  <= rdata_i;
      end
    end
  end

  p_err_differs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> err_exp_o != err_obs_o);
  p_err_after_check_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> $past(ck_i));
  p_complement_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_i |-> (wdata_o ^ pat_i) == (down_i ? '0 : '1));
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PASS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [ADDR_W-1:0] hi_addr_i,
  input  logic [PASS_W-1:0] passes_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              err_valid_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [31:0]       err_exp_o,
  output logic [31:0]       err_obs_o
);
  logic              ck, down, pg_load, pg_adv;
  logic [PASS_W-1:0] pg_pass;
  pat_mode_e         pg_mode;
  word_t             pat;

  march_seq #(.ADDR_W(ADDR_W), .PASS_W(PASS_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .mode_i     (pat_mode_e'(mode_i)),
    .lo_i       (lo_addr_i),
    .hi_i       (hi_addr_i),
    .passes_i,
    .mem_addr_o, .mem_we_o, .mem_re_o,
    .ck_o       (ck),
    .down_o     (down),
    .pg_mode_o  (pg_mode),
    .pg_load_o  (pg_load),
    .pg_pass_o  (pg_pass),
    .pg_adv_o   (pg_adv),
    .busy_o, .done_o
  );

  march_patgen #(.PASS_W(PASS_W)) u_pat (
    .clk_i, .rst_ni,
    .mode_i (pg_mode),
    .load_i (pg_load),
    .pass_i (pg_pass),
    .adv_i  (pg_adv),
    .down_i (down),
    .pat_o  (pat)
  );

  march_check #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i, .rst_ni,
    .ck_i    (ck),
    .down_i  (down),
    .addr_i  (mem_addr_o),
    .pat_i   (pat),
    .rdata_i (mem_rdata_i),
    .wdata_o (mem_wdata_o),
    .err_valid_o, .err_addr_o, .err_exp_o, .err_obs_o
  );
endmodule

// File: tb/march_bist_test.sv
module march_bist_test;
  localparam int AW = 8;
  localparam int PW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [AW-1:0] lo_addr_i = '0, hi_addr_i = '0;
  logic [PW-1:0] passes_i = '0;
  logic          busy_o, done_o, mem_we_o, mem_re_o, err_valid_o;
  logic [AW-1:0] mem_addr_o, err_addr_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i, err_exp_o, err_obs_o;

  march_bist #(.ADDR_W(AW), .PASS_W(PW)) uut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0;

  // RAM model with a stuck-at-one read mask on one address
  logic [31:0]   mem [256];
  logic [AW-1:0] f_addr = '0;
  logic [31:0]   f_mask = '0;
  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o] | ((mem_addr_o == f_addr) ? f_mask : 32'h0);
  end

  logic [AW-1:0] wa_q[$], ra_q[$], ea_q[$];
  logic [31:0]   wd_q[$], ee_q[$], eo_q[$];
  always @(negedge clk_i) begin
    if (mem_we_o) begin wa_q.push_back(mem_addr_o); wd_q.push_back(mem_wdata_o); end
    if (mem_re_o) ra_q.push_back(mem_addr_o);
    if (err_valid_o) begin
      ea_q.push_back(err_addr_o); ee_q.push_back(err_exp_o); eo_q.push_back(err_obs_o);
    end
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_next(logic [31:0] s);
    logic fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    return {s[30:0], fb};
  endfunction

  function automatic logic [31:0] ref_pat(int mode, int p, int k);
    logic [31:0] s;
    logic [7:0]  b;
    int          i;
    case (mode)
      0: s = (p % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
      1: begin
        i = p % 20;
        if (i < 8) b = 8'(1 << i);
        else if (i < 16) b = ~8'(1 << (i - 8));
        else b = (i == 16) ? 8'h55 : (i == 17) ? 8'hAA : (i == 18) ? 8'h33 : 8'hCC;
        s = {b, b, b, b};
      end
      2: begin
        s = 32'h1D87_2B41 ^ (32'(p) * 32'h9E37_79B9);
        if (s == 0) s = 32'h1;
        for (int j = 0; j < k; j++) s = ref_next(s);
      end
      default: s = 32'h1 << ((p + k) % 32);
    endcase
    return s;
  endfunction

  task automatic run(string tag, int mode, int lo, int hi, int passes,
                     int fa, logic [31:0] fm, bit disturb);
    logic [AW-1:0] xwa[$], xra[$], xea[$];
    logic [31:0]   xwd[$], xee[$], xeo[$];
    int n = hi - lo + 1;
    int pe = (passes == 0) ? 1 : passes;
    int busy_n = 0;
    bit ok;
    logic [31:0] v;
    wa_q.delete(); wd_q.delete(); ra_q.delete(); ea_q.delete(); ee_q.delete(); eo_q.delete();
    f_addr = AW'(fa); f_mask = fm;
    mode_i = 2'(mode); lo_addr_i = AW'(lo); hi_addr_i = AW'(hi); passes_i = PW'(passes);
    start_i = 1'b1;
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (cyc == 0) check(!done_o && busy_o, "R9", {tag, " start clears done"}, {done_o, busy_o}, 2'b01);
      if (disturb && cyc == 3) begin  // R10: scramble config and re-pulse start mid-run
        mode_i = 2'(mode + 1); lo_addr_i = 0; hi_addr_i = 200; passes_i = 9; start_i = 1'b1;
      end
      if (busy_o) busy_n++; else break;
    end
    @(negedge clk_i);
    check(busy_n == pe * 5 * n, "R9", {tag, " busy cycles"}, busy_n, pe * 5 * n);
    check(done_o && !busy_o, "R9", {tag, " done held"}, {done_o, busy_o}, 2'b10);
    for (int p = 0; p < pe; p++) begin
      for (int k = 0; k < n; k++) begin xwa.push_back(AW'(lo + k)); xwd.push_back(ref_pat(mode, p, k)); end
      for (int k = 0; k < n; k++) begin
        v = ref_pat(mode, p, k);
        xra.push_back(AW'(lo + k)); xwa.push_back(AW'(lo + k)); xwd.push_back(~v);
        if (lo + k == fa && (v | fm) != v) begin xea.push_back(AW'(fa)); xee.push_back(v); xeo.push_back(v | fm); end
      end
      for (int k = n - 1; k >= 0; k--) begin
        v = ~ref_pat(mode, p, k);
        xra.push_back(AW'(lo + k)); xwa.push_back(AW'(lo + k)); xwd.push_back(~v);
        if (lo + k == fa && (v | fm) != v) begin xea.push_back(AW'(fa)); xee.push_back(v); xeo.push_back(v | fm); end
      end
    end
    ok = (wa_q.size() == xwa.size());
    for (int i = 0; ok && i < xwa.size(); i++) ok = (wa_q[i] == xwa[i]) && (wd_q[i] == xwd[i]);
    check(ok, "R1 R2 R3 R4 R5 R6 R7", {tag, " write stream (count)"}, wa_q.size(), xwa.size());
    ok = (ra_q.size() == xra.size());
    for (int i = 0; ok && i < xra.size(); i++) ok = (ra_q[i] == xra[i]);
    check(ok, "R2 R3", {tag, " read stream (count)"}, ra_q.size(), xra.size());
    ok = (ea_q.size() == xea.size());
    for (int i = 0; ok && i < xea.size(); i++) ok = (ea_q[i] == xea[i]) && (ee_q[i] == xee[i]) && (eo_q[i] == xeo[i]);
    check(ok, "R8", {tag, " error reports (count)"}, ea_q.size(), xea.size());
    if (xea.size() > 0 && ea_q.size() > 0)
      check(eo_q[0] == xeo[0], "R8", {tag, " first observed word"}, eo_q[0], xeo[0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !err_valid_o && !mem_we_o && !mem_re_o, "R9", "reset state",
          {busy_o, done_o, err_valid_o, mem_we_o, mem_re_o}, 5'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o, "R9", "idle after reset", {busy_o, done_o}, 2'b00);

    run("solid_r4", 0, 3, 10, 2, 0, 32'h0, 1'b0);
    run("walk_wrap_r7", 1, 0, 1, 21, 0, 32'h0, 1'b0);
    run("rand_fault_r5", 2, 5, 20, 3, 9, 32'h0000_0010, 1'b0);
    run("rot_wrap_r6", 3, 0, 2, 33, 1, 32'h8000_0000, 1'b0);
    run("top_single_r1", 0, 255, 255, 0, 255, 32'h0000_0001, 1'b0);
    run("disturb_r10", 2, 2, 9, 2, 0, 32'h0, 1'b1);
    for (int t = 0; t < 6; t++) begin
      int lo = $urandom_range(0, 240);
      run("random_mix", $urandom_range(0, 3), lo, lo + $urandom_range(0, 15), $urandom_range(0, 3),
          lo + $urandom_range(0, 15), 32'h1 << $urandom_range(0, 31), 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule